// File: doc/BRIEF.md
# USB Device Controller Control and Configuration Registers

This block holds the two byte-wide registers that steer a USB device controller: a control register that supervises soft reset, power-down, enumeration pull-up, remote wake-up and oscillator wake, and a configuration register that carries the global enable. A host processor reaches both over a simple byte register bus with a 5-bit address, a write strobe and combinational read data. The block turns the stored bits into the enable, reset and request lines used by the rest of the controller.

Two reset domains exist. The power-on reset (`por_n`) is the only thing that initialises either register. The controller soft-reset bit in the control register resets the rest of the controller through `core_rst_o`, but it does not reset this block's own registers. The pull-up request can be made to depend on VBUS presence. A small wake state machine handles the oscillator while the controller is powered down. It synchronises D+ activity through two flops and latches the oscillator on when resume activity is seen.

The wake machine has three states. `WK_RUN`: power-down is clear and the oscillator is enabled. `WK_SLEEP`: power-down is set and the oscillator is off. `WK_WAKE`: power-down is still set, but resume activity turned the oscillator back on. Its transitions are:
- `RUN->SLEEP` when power-down is 1.
- `SLEEP->WAKE` when the synchronised D+ activity is 1 and oscillator-start is 1.
- `SLEEP->RUN` and `WAKE->RUN` when power-down is 0.

`WAKE` is held until power-down clears. The machine resets into `WK_SLEEP`, because power-down resets to 1.

Top module: `usb_ctl_regs`

## Requirements
- R1: After power-on reset, address 02h reads 0xB0 and address 03h reads 0x00. `core_rst_o` and `lowpow_req_o` are 1. `osc_en_o`, `usb_en_o`, `traffic_en_o`, `pullup_req_o` and `rwake_req_o` are 0.
- R2: The control register at 02h has these bits: 7 oscillator-start, 6 VBUS-gate, 5 soft reset, 4 power-down, 3 connect, 2 remote wake. The configuration register at 03h has the enable at bit 0. Written values read back, except that reserved bits (02h bits 1:0, 03h bits 7:1) always read 0.
- R3: Any address other than 02h and 03h reads 0x00. Writes to such an address change neither register.
- R4: `core_rst_o` equals the soft-reset bit and stays 1 until software writes it 0. The soft-reset bit does not change the configuration register or the other control bits.
- R5: `pullup_req_o` is connect AND (VBUS-present OR NOT VBUS-gate).
- R6: `usb_en_o` equals the enable bit. `traffic_en_o` is 1 only when enable is 1 and soft reset is 0.
- R7: `lowpow_req_o` equals the power-down bit.
- R8: `rwake_req_o` equals the remote-wake bit. That bit reads 0 whenever the soft-reset bit is 1, including when both are written 1 in the same write.
- R9: In `WK_SLEEP` with oscillator-start 1, a D+ activity level raises `osc_en_o` on the third rising edge after it is applied. `osc_en_o` then stays 1 after the activity goes away, for as long as power-down stays set.
- R10: With oscillator-start 0, D+ activity during power-down leaves `osc_en_o` at 0.
- R11: `osc_en_o` changes on the edge after the power-down bit changes. It goes to 1 one cycle after a write that clears power-down, and to 0 one cycle after a write that sets it from `WK_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| vbus_present | input | 1 | VBUS detected |
| dp_activity | input | 1 | Asynchronous D+ activity level |
| pullup_req_o | output | 1 | Enumeration pull-up request |
| core_rst_o | output | 1 | Soft reset to the rest of the controller |
| lowpow_req_o | output | 1 | Low-power request |
| rwake_req_o | output | 1 | Remote wake-up signalling request |
| osc_en_o | output | 1 | Oscillator enable |
| usb_en_o | output | 1 | Global controller enable |
| traffic_en_o | output | 1 | Permission to respond to bus traffic |

## Verification
The outputs fall into three timing groups:
- Read data, pull-up, reset, low-power, remote-wake and the two enables follow the registers combinationally. They are due right after the write edge, and the bench samples them on the falling edge that follows the write.
- `osc_en_o` lags a power-down write by exactly one more rising edge. The bench checks that it is still at its old value on the first falling edge and at its new value one cycle later.
- D+ activity passes two synchroniser flops and the state register. The bench checks that `osc_en_o` is still 0 after two rising edges and 1 after the third.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTL = 5'h02;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 5'h03;

    // control register bit positions
    localparam int B_OSCST = 7;
    localparam int B_VGATE = 6;
    localparam int B_SRST  = 5;
    localparam int B_PDN   = 4;
    localparam int B_CONN  = 3;
    localparam int B_RWAKE = 2;
    // configuration register bit position
    localparam int B_EN    = 0;

    localparam logic [DATA_W-1:0] CTL_RST_VAL  = 8'hB0;
    localparam logic [DATA_W-1:0] CTL_WR_MASK  = 8'hFC;
    localparam logic [DATA_W-1:0] CFG_RST_VAL  = 8'h00;
    localparam logic [DATA_W-1:0] CFG_WR_MASK  = 8'h01;

    typedef enum logic [1:0] {
        WK_RUN   = 2'd0,
        WK_SLEEP = 2'd1,
        WK_WAKE  = 2'd2
    } wake_state_t;
endpackage

// File: rtl/usbctl_ctrl_reg.sv
module usbctl_ctrl_reg
    import usbctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_o
);
    logic [W-1:0] ctl_q;
    logic [W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d = wdata_i & CTL_WR_MASK;
        end
        // remote wake cannot survive while soft reset is requested
        if (ctl_d[B_SRST]) begin
            ctl_d[B_RWAKE] = 1'b0;
        end
    end

    // power-on reset only: soft reset leaves this register alone
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= CTL_RST_VAL;
        else        ctl_q <= ctl_d;
    end

    assign value_o = ctl_q;

    AST_RWAKE_NOT_IN_SRST: assert property (@(posedge clk) disable iff (!por_n)
        !(ctl_q[B_SRST] && ctl_q[B_RWAKE])); // R8
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !wr_i |=> $stable(ctl_q)); // R4
endmodule

// File: rtl/usbctl_cfg_reg.sv
module usbctl_cfg_reg
    import usbctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_o
);
    logic [W-1:0] cfg_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)    cfg_q <= CFG_RST_VAL;
        else if (wr_i) cfg_q <= wdata_i & CFG_WR_MASK;
    end

    assign value_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !wr_i |=> $stable(cfg_q)); // R4
    AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_q & ~CFG_WR_MASK) == '0); // R2
endmodule

// File: rtl/usbctl_wake_fsm.sv
module usbctl_wake_fsm
    import usbctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pdn_i,
    input  logic oscst_i,
    input  logic dp_raw_i,
    output logic osc_en_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   dp_seen;
    wake_state_t            state_q;
    wake_state_t            state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q <= '0;
                else        sync_q <= dp_raw_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], dp_raw_i};
            end
        end
    endgenerate

    assign dp_seen = sync_q[SYNC_STAGES-1];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_RUN:   if (pdn_i) state_d = WK_SLEEP;
            WK_SLEEP: begin
                if (!pdn_i)                   state_d = WK_RUN;
                else if (dp_seen && oscst_i)  state_d = WK_WAKE;
            end
            WK_WAKE:  if (!pdn_i) state_d = WK_RUN;
            default:  state_d = WK_SLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= WK_SLEEP;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            WK_RUN:   osc_en_o = 1'b1;
            WK_WAKE:  osc_en_o = 1'b1;
            WK_SLEEP: osc_en_o = 1'b0;
            default:  osc_en_o = 1'b0;
        endcase
    end

    AST_NO_WAKE_WITHOUT_OSCST: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WK_SLEEP && !oscst_i) |=> state_q != WK_WAKE); // R10
    AST_RUN_WHEN_AWAKE: assert property (@(posedge clk) disable iff (!por_n)
        !pdn_i |=> state_q == WK_RUN); // R11
    AST_WAKE_LATCHED: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WK_WAKE && pdn_i) |=> state_q == WK_WAKE); // R9
    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!por_n)
        state_q inside {WK_RUN, WK_SLEEP, WK_WAKE}); // R9
endmodule

// File: rtl/usb_ctl_regs.sv
module usb_ctl_regs
    import usbctl_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          vbus_present,
    input  logic          dp_activity,
    output logic          pullup_req_o,
    output logic          core_rst_o,
    output logic          lowpow_req_o,
    output logic          rwake_req_o,
    output logic          osc_en_o,
    output logic          usb_en_o,
    output logic          traffic_en_o
);
    logic          hit_ctl;
    logic          hit_cfg;
    logic [DW-1:0] ctl_v;
    logic [DW-1:0] cfg_v;

    assign hit_ctl = (bus_addr == ADDR_CTL);
    assign hit_cfg = (bus_addr == ADDR_CFG);

    usbctl_ctrl_reg #(.W(DW)) u_ctl (
        .clk     (clk),
        .por_n   (por_n),
        .wr_i    (bus_we && hit_ctl),
        .wdata_i (bus_wdata),
        .value_o (ctl_v)
    );

    usbctl_cfg_reg #(.W(DW)) u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_i    (bus_we && hit_cfg),
        .wdata_i (bus_wdata),
        .value_o (cfg_v)
    );

    usbctl_wake_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk      (clk),
        .por_n    (por_n),
        .pdn_i    (ctl_v[B_PDN]),
        .oscst_i  (ctl_v[B_OSCST]),
        .dp_raw_i (dp_activity),
        .osc_en_o (osc_en_o)
    );

    always_comb begin
        if (hit_ctl)      bus_rdata = ctl_v;
        else if (hit_cfg) bus_rdata = cfg_v;
        else              bus_rdata = '0;
    end

    assign pullup_req_o = ctl_v[B_CONN] && (vbus_present || !ctl_v[B_VGATE]);
    assign core_rst_o   = ctl_v[B_SRST];
    assign lowpow_req_o = ctl_v[B_PDN];
    assign rwake_req_o  = ctl_v[B_RWAKE];
    assign usb_en_o     = cfg_v[B_EN];
    assign traffic_en_o = cfg_v[B_EN] && !ctl_v[B_SRST];

    AST_TRAFFIC_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
        traffic_en_o |-> (usb_en_o && !core_rst_o)); // R6
    AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        hit_ctl |-> bus_rdata[1:0] == 2'b00); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (!hit_ctl && !hit_cfg) |-> bus_rdata == '0); // R3
    AST_NO_PULLUP_NO_VBUS: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_v[B_VGATE] && !vbus_present) |-> !pullup_req_o); // R5
endmodule

// File: tb/usb_ctl_regs_test.sv
`timescale 1ns/1ps
module usb_ctl_regs_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       vbus_present = 1'b0;
    logic       dp_activity = 1'b0;
    logic       pullup_req_o, core_rst_o, lowpow_req_o, rwake_req_o;
    logic       osc_en_o, usb_en_o, traffic_en_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_ctl_regs uut (
        .clk(clk), .por_n(por_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vbus_present(vbus_present), .dp_activity(dp_activity),
        .pullup_req_o(pullup_req_o), .core_rst_o(core_rst_o),
        .lowpow_req_o(lowpow_req_o), .rwake_req_o(rwake_req_o),
        .osc_en_o(osc_en_o), .usb_en_o(usb_en_o), .traffic_en_o(traffic_en_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write at a rising edge, return on the following falling edge
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(5'h02, v); chk("R1 ctl", v, 8'hB0);
        rd(5'h03, v); chk("R1 cfg", v, 8'h00);
        chk("R1 outs", {core_rst_o, lowpow_req_o, osc_en_o, usb_en_o,
                        traffic_en_o, pullup_req_o, rwake_req_o, 1'b0}, 8'hC0);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(5'h02, 8'hFF); rd(5'h02, v); chk("R2 ctl rsvd/rwake", v, 8'hFC & ~8'h04);
        wr(5'h03, 8'hFF); rd(5'h03, v); chk("R2 cfg rsvd", v, 8'h01);
        wr(5'h02, 8'h9C); rd(5'h02, v); chk("R2 ctl pattern", v, 8'h9C);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(5'h05, 8'hAA); rd(5'h05, v); chk("R3 unmapped read", v, 8'h00);
        wr(5'h1F, 8'h00); rd(5'h1F, v); chk("R3 unmapped read hi", v, 8'h00);
        rd(5'h02, v); chk("R3 ctl untouched", v, 8'h9C);
        rd(5'h03, v); chk("R3 cfg untouched", v, 8'h01);
    endtask

    task automatic t_srst();
        logic [7:0] v;
        wr(5'h02, 8'hB8);
        chk("R4 core_rst", core_rst_o, 1);
        cyc(4);
        rd(5'h03, v); chk("R4 cfg survives", v, 8'h01);
        rd(5'h02, v); chk("R4 ctl survives", v, 8'hB8);
        chk("R6 traffic off in srst", traffic_en_o, 0);
        chk("R6 usb_en", usb_en_o, 1);
        wr(5'h02, 8'h98);
        chk("R4 core_rst cleared", core_rst_o, 0);
        chk("R6 traffic on", traffic_en_o, 1);
        wr(5'h03, 8'h00);
        chk("R6 traffic off no en", traffic_en_o, 0);
    endtask

    task automatic t_connect();
        vbus_present = 1'b0;
        wr(5'h02, 8'h08); chk("R5 ungated", pullup_req_o, 1);
        wr(5'h02, 8'h48); chk("R5 gated no vbus", pullup_req_o, 0);
        vbus_present = 1'b1; #1; chk("R5 gated vbus", pullup_req_o, 1);
        wr(5'h02, 8'h40); chk("R5 no connect", pullup_req_o, 0);
    endtask

    task automatic t_rwake_pd();
        wr(5'h02, 8'h04); chk("R8 rwake on", rwake_req_o, 1);
        chk("R7 lowpow off", lowpow_req_o, 0);
        wr(5'h02, 8'h24); chk("R8 rwake blocked by srst", rwake_req_o, 0);
        wr(5'h02, 8'h90); chk("R7 lowpow on", lowpow_req_o, 1);
    endtask

    task automatic t_pd_timing();
        wr(5'h02, 8'h80);
        chk("R11 osc before edge", osc_en_o, 0);
        cyc(1); chk("R11 osc on", osc_en_o, 1);
        wr(5'h02, 8'h90);
        chk("R11 osc still on", osc_en_o, 1);
        cyc(1); chk("R11 osc off", osc_en_o, 0);
    endtask

    task automatic t_wake();
        dp_activity = 1'b1;
        cyc(2); chk("R9 osc after 2 edges", osc_en_o, 0);
        cyc(1); chk("R9 osc after 3 edges", osc_en_o, 1);
        dp_activity = 1'b0;
        cyc(5); chk("R9 latched", osc_en_o, 1);
        wr(5'h02, 8'h80); cyc(1); chk("R9 run", osc_en_o, 1);
    endtask

    task automatic t_no_oscst();
        wr(5'h02, 8'h10); cyc(1);
        chk("R10 sleep", osc_en_o, 0);
        dp_activity = 1'b1;
        cyc(6); chk("R10 inhibited", osc_en_o, 0);
        dp_activity = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_unmapped();
        t_srst();
        t_connect();
        t_rwake_pd();
        t_pd_timing();
        t_wake();
        t_no_oscst();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule